// File: doc/BRIEF.md
# Memory tag check unit

This unit checks one load or store against a 4-bit tag that is stored for each memory granule. The caller presents a 64-bit virtual pointer and a packed access descriptor on a valid/ready request channel. Two per-access flags travel with the request: a probe flag and a strip flag.

The unit first decides whether the access needs checking at all. Pointer bit 55 picks which half of the address space applies, and so picks one of two top-byte-ignore enables and one of two match-all enables in the descriptor. An access that does not need checking finishes without touching tag storage.

An access that does need checking issues one lookup on a request/response tag port. It then compares the logical tag carried in the pointer with the returned allocation tag. It reports pass or fail with a single-cycle `done` pulse. A failure raises `fault` together with the access's MMU index, except in probe mode, where only `pass` is lowered. The result also carries a pointer that is either unchanged or has its top byte sign-extended from bit 55.

Back-pressure rules: `chk_ready` is high only while no check is in flight, and a request is taken in any cycle where `chk_valid && chk_ready`. `tag_req_valid` stays high, with its payload unchanged, until the cycle in which `tag_req_ready` is seen. `tag_rsp_ready` is high only while a response is awaited, and a response is taken only when `tag_rsp_valid && tag_rsp_ready`.

Top module: `tag_check_unit`

## Requirements
- R1: For a checked access with tag storage present, `pass` is 1 exactly when pointer bits 59:56 equal `tag_rsp_tag`.
- R2: If descriptor bit (4 + ptr[55]) is 0, the access is unchecked and no tag request is made. `done` and `pass` are 1 one cycle after acceptance, with `res_ptr` equal to the input pointer even when strip is requested.
- R3: If descriptor bit (6 + ptr[55]) is 1 and ptr[59:55] is all zeros or all ones (that is, (ptr[59:56] + ptr[55]) mod 16 == 0), the access passes without a tag request. If only the other half's bit is set, or the bits are mixed, a lookup is made.
- R4: Descriptor layout: bits 3:0 hold the MMU index, bits 5:4 the top-byte enables, bits 7:6 the match-all enables, bit 8 the write flag and bits 13:9 the element size. A tag request carries the full pointer, the write flag, the element size and the MMU index.
- R5: A response with `tag_rsp_absent` = 1 makes the access pass whatever the tag value.
- R6: A failed check gives `pass` = 0. Without probe it also gives `fault` = 1 with `fault_midx` equal to the MMU index. With probe, `fault` stays 0.
- R7: With strip requested and the selected top-byte enable set, `res_ptr` bits 63:56 are copies of bit 55 and bits 55:0 are unchanged.
- R8: A checked access pulses `done` for one cycle, one cycle after the response handshake. A response offered while none is awaited is not taken and produces no `done`.
- R9: `chk_ready` is low from acceptance of a checked access until its result. `tag_req_valid` and `tag_req_addr` are held until `tag_req_ready`.
- R10: After reset, `chk_ready` = 1 and `done`, `fault`, `tag_req_valid` and `tag_rsp_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Check request valid |
| chk_ready | output | 1 | Unit can take a request |
| chk_ptr | input | 64 | Virtual pointer with tag |
| chk_desc | input | 14 | Packed access descriptor |
| chk_probe | input | 1 | Probe only: report without fault |
| chk_strip | input | 1 | Return pointer with cleaned top byte |
| tag_req_valid | output | 1 | Tag lookup request valid |
| tag_req_ready | input | 1 | Tag lookup request taken |
| tag_req_addr | output | 64 | Pointer to look up |
| tag_req_write | output | 1 | Access is a store |
| tag_req_esize | output | 5 | Element size field |
| tag_req_midx | output | 4 | MMU index |
| tag_rsp_valid | input | 1 | Tag response valid |
| tag_rsp_ready | output | 1 | Unit awaits a response |
| tag_rsp_absent | input | 1 | No tag storage for this address |
| tag_rsp_tag | input | 4 | Stored allocation tag |
| done | output | 1 | Result pulse |
| pass | output | 1 | Access passed (valid with done) |
| fault | output | 1 | Tag check fault (with done) |
| fault_midx | output | 4 | MMU index of faulting access |
| res_ptr | output | 64 | Result pointer (valid with done) |

## Verification
The assertions assume that the tag port returns at most one response per request and only after the request handshake. They also assume that `tag_rsp_absent` and `tag_rsp_tag` carry meaning only while `tag_rsp_valid` is high, and that inputs are known once reset is released. The stimulus respects these limits by driving all inputs at the falling edge and offering a single response only after each request has been taken. The one exception is a stray response sent while the unit is idle, which checks that nothing is taken.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int PTR_W   = 64;
  localparam int TAG_W   = 4;
  localparam int MIDX_W  = 4;
  localparam int ESIZE_W = 5;
  localparam int TAG_LSB = 56;
  localparam int SEL_BIT = 55;
  localparam int TOP_W   = PTR_W - TAG_LSB;
  localparam int DESC_W  = MIDX_W + 2 + 2 + 1 + ESIZE_W;

  // Packed MSB first: esize[13:9], write[8], tcma[7:6], tbi[5:4], midx[3:0]
  typedef struct packed {
    logic [ESIZE_W-1:0] esize;
    logic               write;
    logic [1:0]         tcma;
    logic [1:0]         tbi;
    logic [MIDX_W-1:0]  midx;
  } desc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;
endpackage

// File: rtl/tcu_gate.sv
// Decides whether an access needs a tag lookup.
module tcu_gate
  import tcu_pkg::*;
(
  input  logic [TAG_W:0] ptr_top,   // {ptr[59:56], ptr[55]}
  input  logic [1:0]     tbi_en,
  input  logic [1:0]     tcma_en,
  output logic           tbi_on,
  output logic           checked
);
  logic             sel;
  logic [TAG_W-1:0] folded;
  logic             tcma_hit;

  assign sel    = ptr_top[0];
  assign tbi_on = tbi_en[sel];
  // all-zero or all-one top field folds to zero after adding the select bit
  assign folded   = ptr_top[TAG_W:1] + {{(TAG_W-1){1'b0}}, sel};
  assign tcma_hit = tcma_en[sel] && (folded == '0);
  assign checked  = tbi_on && !tcma_hit;
endmodule

// File: rtl/tcu_ptr_clean.sv
// Optionally replaces the top byte with the sign of bit 55.
module tcu_ptr_clean
  import tcu_pkg::*;
(
  input  logic [PTR_W-1:0] ptr_in,
  input  logic             strip,
  input  logic             tbi_on,
  output logic [PTR_W-1:0] ptr_out
);
  logic do_strip;
  assign do_strip = strip && tbi_on;
  assign ptr_out[TAG_LSB-1:0] = ptr_in[TAG_LSB-1:0];

  for (genvar i = TAG_LSB; i < PTR_W; i++) begin : g_top
    assign ptr_out[i] = do_strip ? ptr_in[SEL_BIT] : ptr_in[i];
  end
endmodule

// File: rtl/tcu_tag_cmp.sv
// Compares logical and allocation tags and forms the verdict.
module tcu_tag_cmp
  import tcu_pkg::*;
(
  input  logic [TAG_W-1:0]  ptr_tag,
  input  logic [TAG_W-1:0]  mem_tag,
  input  logic              absent,
  input  logic              probe,
  input  logic [MIDX_W-1:0] midx,
  output logic              ok,
  output logic              flt,
  output logic [MIDX_W-1:0] flt_midx
);
  assign ok       = absent || (ptr_tag == mem_tag);
  assign flt      = !ok && !probe;
  assign flt_midx = flt ? midx : '0;
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tcu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_valid,
  output logic               chk_ready,
  input  logic [PTR_W-1:0]   chk_ptr,
  input  logic [DESC_W-1:0]  chk_desc,
  input  logic               chk_probe,
  input  logic               chk_strip,
  output logic               tag_req_valid,
  input  logic               tag_req_ready,
  output logic [PTR_W-1:0]   tag_req_addr,
  output logic               tag_req_write,
  output logic [ESIZE_W-1:0] tag_req_esize,
  output logic [MIDX_W-1:0]  tag_req_midx,
  input  logic               tag_rsp_valid,
  output logic               tag_rsp_ready,
  input  logic               tag_rsp_absent,
  input  logic [TAG_W-1:0]   tag_rsp_tag,
  output logic               done,
  output logic               pass,
  output logic               fault,
  output logic [MIDX_W-1:0]  fault_midx,
  output logic [PTR_W-1:0]   res_ptr
);
  desc_t  desc_in;
  state_e st;

  logic               tbi_on, checked;
  logic [PTR_W-1:0]   clean_ptr;
  logic [PTR_W-1:0]   ptr_q, clean_q;
  logic [MIDX_W-1:0]  midx_q;
  logic               write_q, probe_q;
  logic [ESIZE_W-1:0] esize_q;
  logic               cmp_ok, cmp_flt;
  logic [MIDX_W-1:0]  cmp_midx;
  logic               accept, rsp_take;

  assign desc_in = chk_desc;

  tcu_gate u_gate (
    .ptr_top (chk_ptr[TAG_LSB+TAG_W-1:SEL_BIT]),
    .tbi_en  (desc_in.tbi),
    .tcma_en (desc_in.tcma),
    .tbi_on  (tbi_on),
    .checked (checked)
  );

  tcu_ptr_clean u_clean (
    .ptr_in  (chk_ptr),
    .strip   (chk_strip),
    .tbi_on  (tbi_on),
    .ptr_out (clean_ptr)
  );

  tcu_tag_cmp u_cmp (
    .ptr_tag  (ptr_q[TAG_LSB+TAG_W-1:TAG_LSB]),
    .mem_tag  (tag_rsp_tag),
    .absent   (tag_rsp_absent),
    .probe    (probe_q),
    .midx     (midx_q),
    .ok       (cmp_ok),
    .flt      (cmp_flt),
    .flt_midx (cmp_midx)
  );

  assign chk_ready     = (st == ST_IDLE);
  assign tag_req_valid = (st == ST_REQ);
  assign tag_rsp_ready = (st == ST_WAIT);
  assign tag_req_addr  = ptr_q;
  assign tag_req_write = write_q;
  assign tag_req_esize = esize_q;
  assign tag_req_midx  = midx_q;
  assign accept   = chk_valid && chk_ready;
  assign rsp_take = tag_rsp_valid && tag_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ptr_q      <= '0;
      clean_q    <= '0;
      midx_q     <= '0;
      write_q    <= 1'b0;
      esize_q    <= '0;
      probe_q    <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      fault      <= 1'b0;
      fault_midx <= '0;
      res_ptr    <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          ptr_q   <= chk_ptr;
          clean_q <= clean_ptr;
          midx_q  <= desc_in.midx;
          write_q <= desc_in.write;
          esize_q <= desc_in.esize;
          probe_q <= chk_probe;
          if (checked) begin
            st <= ST_REQ;
          end else begin
            done       <= 1'b1;
            pass       <= 1'b1;
            fault_midx <= '0;
            res_ptr    <= clean_ptr;
          end
        end
        ST_REQ: if (tag_req_ready) st <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          st         <= ST_IDLE;
          done       <= 1'b1;
          pass       <= cmp_ok;
          fault      <= cmp_flt;
          fault_midx <= cmp_midx;
          res_ptr    <= clean_q;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Request payload held under back-pressure
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req_valid && !tag_req_ready |=> tag_req_valid && $stable(tag_req_addr));

  // No new check taken while a lookup is outstanding
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req_valid || tag_rsp_ready) |-> !chk_ready);

  // Top-byte-ignore disabled: immediate pass with the unchanged pointer
  assert_tbi_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_ready && !desc_in.tbi[chk_ptr[SEL_BIT]]
    |=> done && pass && !fault && (res_ptr == $past(chk_ptr)));

  // Missing tag storage always passes
  assert_absent_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rsp_valid && tag_rsp_ready && tag_rsp_absent |=> done && pass && !fault);

  // A fault only accompanies a failing result
  assert_fault_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done && !pass);

  // Result arrives one cycle after the response handshake
  assert_rsp_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rsp_valid && tag_rsp_ready |=> done && chk_ready);
endmodule

// File: tb/tag_check_unit_tb_top.sv
`timescale 1ns/100ps
module tag_check_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic        chk_ready;
  logic [63:0] chk_ptr = '0;
  logic [13:0] chk_desc = '0;
  logic        chk_probe = 1'b0, chk_strip = 1'b0;
  logic        tag_req_valid, tag_req_ready = 1'b0;
  logic [63:0] tag_req_addr;
  logic        tag_req_write;
  logic [4:0]  tag_req_esize;
  logic [3:0]  tag_req_midx;
  logic        tag_rsp_valid = 1'b0, tag_rsp_ready;
  logic        tag_rsp_absent = 1'b0;
  logic [3:0]  tag_rsp_tag = '0;
  logic        done, pass, fault;
  logic [3:0]  fault_midx;
  logic [63:0] res_ptr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tag_check_unit dut_i (.*);

  task automatic expect_eq(string rq, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [13:0] mk_desc(logic [4:0] es, logic wr, logic [1:0] tcma,
                                          logic [1:0] tbi, logic [3:0] midx);
    return {es, wr, tcma, tbi, midx};
  endfunction

  // Reference model for one check, then cycle-by-cycle comparison
  task automatic run(string rq, logic [63:0] p, logic [13:0] d, logic pr, logic stp,
                     logic [3:0] mt, logic ab, int req_dly, int rsp_dly);
    int b55 = int'(p[55]);
    logic tbi = d[4 + b55];
    logic [3:0] tg = p[59:56];
    logic hit = d[6 + b55] && (((int'(tg) + b55) % 16) == 0);
    logic bypass = !tbi || hit;
    logic [63:0] eptr = (tbi && stp) ? {{8{p[55]}}, p[55:0]} : p;
    logic epass = bypass || ab || (tg == mt);
    logic efault = !epass && !pr;

    @(negedge clk);
    expect_eq("R9", "chk_ready idle", chk_ready, 1);
    chk_valid = 1'b1; chk_ptr = p; chk_desc = d; chk_probe = pr; chk_strip = stp;
    @(negedge clk);
    chk_valid = 1'b0;
    if (bypass) begin
      expect_eq("R8", "bypass done", done, 1);
      expect_eq(rq, "bypass no request", tag_req_valid, 0);
      expect_eq(rq, "bypass pass", pass, 1);
      expect_eq(rq, "bypass fault", fault, 0);
      expect_eq(rq, "bypass res_ptr", res_ptr, eptr);
    end else begin
      expect_eq("R8", "no early done", done, 0);
      expect_eq(rq, "request issued", tag_req_valid, 1);
      expect_eq("R9", "busy ready", chk_ready, 0);
      expect_eq("R4", "req addr", tag_req_addr, p);
      expect_eq("R4", "req write", tag_req_write, d[8]);
      expect_eq("R4", "req esize", tag_req_esize, d[13:9]);
      expect_eq("R4", "req midx", tag_req_midx, d[3:0]);
      for (int i = 0; i < req_dly; i++) begin
        @(negedge clk);
        expect_eq("R9", "req held", tag_req_valid, 1);
        expect_eq("R9", "addr held", tag_req_addr, p);
      end
      tag_req_ready = 1'b1;
      @(negedge clk);
      tag_req_ready = 1'b0;
      expect_eq("R9", "req dropped", tag_req_valid, 0);
      expect_eq("R8", "wait rsp_ready", tag_rsp_ready, 1);
      for (int i = 0; i < rsp_dly; i++) begin
        @(negedge clk);
        expect_eq("R8", "no done while waiting", done, 0);
      end
      tag_rsp_valid = 1'b1; tag_rsp_tag = mt; tag_rsp_absent = ab;
      @(negedge clk);
      tag_rsp_valid = 1'b0; tag_rsp_absent = 1'b0;
      expect_eq("R8", "checked done", done, 1);
      expect_eq(rq, "checked pass", pass, epass);
      expect_eq(rq, "checked fault", fault, efault);
      if (efault) expect_eq("R6", "fault midx", fault_midx, d[3:0]);
      expect_eq(rq, "checked res_ptr", res_ptr, eptr);
    end
    @(negedge clk);
    expect_eq("R8", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R10", "reset chk_ready", chk_ready, 1);
    expect_eq("R10", "reset done", done, 0);
    expect_eq("R10", "reset fault", fault, 0);
    expect_eq("R10", "reset req", tag_req_valid, 0);
    expect_eq("R10", "reset rsp_ready", tag_rsp_ready, 0);

    // R2: enable cleared for each half, strip requested yet ignored
    run("R2", 64'h3A00_1234_5678_9ABC, mk_desc(5'd2, 1'b0, 2'b11, 2'b10, 4'd1), 0, 1, 4'h0, 0, 0, 0);
    run("R2", 64'h5B80_0000_0000_1000, mk_desc(5'd2, 1'b1, 2'b00, 2'b01, 4'd2), 0, 1, 4'h0, 0, 0, 0);
    // R3: match-all with zero top and with all-ones top
    run("R3", 64'h0000_0000_0000_0040, mk_desc(5'd0, 1'b0, 2'b01, 2'b11, 4'd3), 0, 0, 4'h9, 0, 0, 0);
    run("R3", 64'hFF80_0000_0000_0080, mk_desc(5'd0, 1'b0, 2'b10, 2'b11, 4'd3), 0, 1, 4'h9, 0, 0, 0);
    // R3: wrong-half match-all bit, and mixed top bits, both take a lookup
    run("R3", 64'h0000_0000_0000_0000, mk_desc(5'd1, 1'b0, 2'b10, 2'b11, 4'd4), 0, 0, 4'h0, 0, 0, 1);
    run("R3", 64'h0100_0000_0000_0010, mk_desc(5'd1, 1'b1, 2'b11, 2'b11, 4'd4), 0, 0, 4'h1, 0, 1, 0);
    // R1 and R7: tag match with strip on each half
    run("R7", 64'h7A80_1111_2222_3330, mk_desc(5'd3, 1'b1, 2'b00, 2'b11, 4'd5), 0, 1, 4'hA, 0, 0, 0);
    run("R1", 64'h2300_4444_5555_6660, mk_desc(5'd4, 1'b0, 2'b00, 2'b01, 4'd6), 0, 1, 4'h3, 0, 1, 1);
    // R6: mismatch with back-pressure, then probe mismatch
    run("R6", 64'h0C00_0000_0000_0100, mk_desc(5'd3, 1'b1, 2'b00, 2'b11, 4'd9), 0, 0, 4'h4, 0, 3, 2);
    run("R6", 64'h0C00_0000_0000_0100, mk_desc(5'd3, 1'b0, 2'b00, 2'b11, 4'd9), 1, 0, 4'h4, 0, 0, 0);
    // R1: mismatch on the upper half
    run("R1", 64'h6E80_0000_0000_0200, mk_desc(5'd0, 1'b0, 2'b00, 2'b10, 4'd12), 0, 0, 4'hD, 0, 0, 0);
    // R5: no tag storage
    run("R5", 64'h0200_0000_0000_0300, mk_desc(5'd0, 1'b0, 2'b00, 2'b11, 4'd7), 0, 0, 4'h7, 1, 0, 0);

    // R8: stray response while idle is not taken
    @(negedge clk);
    tag_rsp_valid = 1'b1; tag_rsp_tag = 4'h5;
    for (int i = 0; i < 2; i++) begin
      expect_eq("R8", "stray rsp_ready", tag_rsp_ready, 0);
      @(negedge clk);
      expect_eq("R8", "stray no done", done, 0);
    end
    tag_rsp_valid = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule